// File: doc/BRIEF.md
# Read-Timing Calibration Window Finder

This block tunes the input-sampling delay of a serial flash read path for one clock divider level. On a start pulse it walks every combination of a coarse half-cycle count (0 to 5) and a fine delay step (0 to 15, each step about 0.5 ns of extra data-input delay). For each combination it asks an external checksum engine to read a reference region with that setting. A setting passes when the returned checksum equals a golden checksum, which the system captured earlier at a slow clock with compensation off.

The pass/fail results sit in a 6-row by 17-column grid. Column 16 of every row is never written and always reads as fail, so a run of passes cannot continue from one row into the next. After the sweep, a serial scan takes one grid index per clock and looks for the longest run of passes. It takes that run's midpoint as the chosen setting and packs it into a compensation byte. The byte goes into the byte lane of a 32-bit word selected by the divider level. If no run reaches four passes, the block reports a failure and gives no value.

The requests to the engine and the responses from it are valid/ready streams. The block holds a request until the engine accepts it. It takes a response only while it waits for one, so the engine may stall either side for any number of cycles.

Top module: `calib_window_finder`

## Requirements
- R1: One sweep issues exactly 96 requests in order: half-cycle count 0 to 5 in the outer loop, fine delay 0 to 15 in the inner loop. Each `req_setting` byte is {delay[3:0], 1'b1, hcycle[2:0]} (bit 3 is the enable).
- R2: Once `req_valid` is high it stays high with a stable `req_setting` until the cycle `req_ready` is high. `rsp_ready` is high only while the block waits for the response to an accepted request, and never in the same cycle as `req_valid`.
- R3: A setting passes exactly when `rsp_sum` equals `golden` in the cycle the response is accepted.
- R4: Results are indexed hcycle*17 + delay. Index 16 of each row always reads as fail, so a pass run never joins the end of one row to the start of the next.
- R5: The scan goes upward through indices 0 to 101 and keeps a count of consecutive passes. Only when the count exceeds the best so far does it record the midpoint, as the index of the last fail (0 before any fail) plus half the count, rounded down. The first of two equally long runs therefore wins.
- R6: If the longest run is shorter than 4, `fail` is 1 and `comp_word` is 0. A run of exactly 4 is accepted.
- R7: The point decodes as hcycle = point / 17 and delay = point mod 17. `comp_word` holds the byte {delay[3:0], 1'b1, hcycle[2:0]} in byte lane `level` (bits level*8+7 down to level*8), and every other bit is 0. `level` is captured when a start is accepted.
- R8: `done` is high for exactly one cycle when a result is ready. `fail` and `comp_word` change only in that cycle and hold their values until the next result.
- R9: A start is ignored while a sweep or scan is in progress. A start in the same cycle that `done` is high is accepted.
- R10: After reset, `done`, `fail`, `comp_word` and `req_valid` are 0.
- R11: All results are cleared when a start is accepted, so passes from a previous sweep never count in a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration when idle |
| level | input | 2 | Divider level 0..3 (fastest four), selects the output byte lane |
| golden | input | 32 | Reference checksum |
| req_valid | output | 1 | Request to the checksum engine is valid |
| req_ready | input | 1 | Checksum engine accepts the request |
| req_setting | output | 8 | Compensation setting under test |
| rsp_valid | input | 1 | Checksum engine has a result |
| rsp_ready | output | 1 | Block accepts a result |
| rsp_sum | input | 32 | Checksum measured with the setting |
| comp_word | output | 32 | Encoded compensation word |
| done | output | 1 | One-cycle result strobe |
| fail | output | 1 | No pass run of at least four settings |

## Verification
Two functions can meet in the same cycle: a new start can arrive while the result strobe of the previous calibration is raised. The bench provokes this by raising `start` in the exact cycle it sees `done`, with a new pass pattern and level already applied. It judges the outcome by three things: `req_valid` rises on the next cycle, `comp_word` still shows the old word at that point, and the second calibration then ends with the word its own pattern calls for after all 96 requests. Back-pressure runs through every vector, because the engine model withholds `req_ready` and delays `rsp_valid` on a rotating pattern.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [1:0] {
    SW_IDLE,
    SW_ISSUE,
    SW_WAIT
  } sweep_st_t;

  // Compensation byte: fine delay high nibble, enable bit, coarse count low bits.
  function automatic logic [7:0] comp_byte(input logic [2:0] hc, input logic [3:0] dl);
    return {dl, 1'b1, hc};
  endfunction

endpackage

// File: rtl/cal_sweep.sv
module cal_sweep
  import cal_pkg::*;
#(
  parameter int HC_ROWS    = 6,
  parameter int FINE_STEPS = 16,
  parameter int SUM_W      = 32,
  parameter int GRID       = 102,
  parameter int IDX_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [SUM_W-1:0] golden,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [7:0]       req_setting,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [SUM_W-1:0] rsp_sum,
  output logic             busy,
  output logic             sweep_done,
  output logic [GRID-1:0]  results
);

  localparam int ROW  = FINE_STEPS + 1;
  localparam int HC_W = $clog2(HC_ROWS);
  localparam int DL_W = $clog2(FINE_STEPS);

  sweep_st_t       st;
  logic [HC_W-1:0] hc;
  logic [DL_W-1:0] dl;
  logic [IDX_W-1:0] slot;
  logic            last_setting;
  logic            row_end;

  assign slot         = IDX_W'(hc) * IDX_W'(ROW) + IDX_W'(dl);
  assign row_end      = (dl == DL_W'(FINE_STEPS - 1));
  assign last_setting = row_end && (hc == HC_W'(HC_ROWS - 1));

  assign req_valid   = (st == SW_ISSUE);
  assign rsp_ready   = (st == SW_WAIT);
  assign busy        = (st != SW_IDLE);
  assign req_setting = comp_byte(3'(hc), 4'(dl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SW_IDLE;
      hc         <= '0;
      dl         <= '0;
      results    <= '0;
      sweep_done <= 1'b0;
    end else begin
      sweep_done <= 1'b0;
      case (st)
        SW_IDLE: begin
          if (launch) begin
            st      <= SW_ISSUE;
            hc      <= '0;
            dl      <= '0;
            results <= '0;
          end
        end
        SW_ISSUE: begin
          if (req_ready) st <= SW_WAIT;
        end
        SW_WAIT: begin
          if (rsp_valid) begin
            results[slot] <= (rsp_sum == golden);
            if (last_setting) begin
              st         <= SW_IDLE;
              sweep_done <= 1'b1;
            end else begin
              st <= SW_ISSUE;
              if (row_end) begin
                dl <= '0;
                hc <= hc + 1'b1;
              end else begin
                dl <= dl + 1'b1;
              end
            end
          end
        end
        default: st <= SW_IDLE;
      endcase
    end
  end

  // R2: a stalled request keeps its valid and its payload
  a_r2_req_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_setting)));

  // R2: an accepted request is followed by a wait for its response
  a_r2_accept_then_wait : assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_valid && rsp_ready));

endmodule

// File: rtl/cal_run_search.sv
module cal_run_search #(
  parameter int ROW   = 17,
  parameter int GRID  = 102,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [GRID-1:0]  results,
  output logic             active,
  output logic             report,
  output logic [IDX_W-1:0] best_len,
  output logic [IDX_W-1:0] mid
);

  localparam int COL_W = $clog2(ROW);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] run_len;
  logic [IDX_W-1:0] fail_at;
  logic [COL_W-1:0] col;
  logic             bit_now;
  logic [IDX_W-1:0] len_n;
  logic [IDX_W-1:0] at_n;

  assign bit_now = results[idx];

  always_comb begin
    len_n = bit_now ? run_len + 1'b1 : '0;
    at_n  = bit_now ? fail_at : idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      report   <= 1'b0;
      idx      <= '0;
      col      <= '0;
      run_len  <= '0;
      fail_at  <= '0;
      best_len <= '0;
      mid      <= '0;
    end else begin
      report <= 1'b0;
      if (go) begin
        active   <= 1'b1;
        idx      <= '0;
        col      <= '0;
        run_len  <= '0;
        fail_at  <= '0;
        best_len <= '0;
        mid      <= '0;
      end else if (active) begin
        run_len <= len_n;
        fail_at <= at_n;
        if (len_n > best_len) begin
          best_len <= len_n;
          mid      <= at_n + (len_n >> 1);
        end
        col <= (col == COL_W'(ROW - 1)) ? '0 : col + 1'b1;
        if (idx == IDX_W'(GRID - 1)) begin
          active <= 1'b0;
          report <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R4: the separator column of every row reads as fail during the scan
  a_r4_separator_fail : assert property (@(posedge clk) disable iff (!rst_n)
    (active && col == COL_W'(ROW - 1)) |-> !bit_now);

endmodule

// File: rtl/cal_encode.sv
module cal_encode
  import cal_pkg::*;
#(
  parameter int ROW     = 17,
  parameter int HC_ROWS = 6,
  parameter int LVL_W   = 2,
  parameter int IDX_W   = 7,
  parameter int WORD_W  = 32
) (
  input  logic [IDX_W-1:0]  point,
  input  logic [LVL_W-1:0]  lane,
  output logic [WORD_W-1:0] word
);

  logic [2:0]       hc_v;
  logic [IDX_W-1:0] base;
  logic [3:0]       dl_v;

  always_comb begin
    hc_v = '0;
    base = '0;
    for (int r = 0; r < HC_ROWS; r++) begin
      if (point >= IDX_W'(r * ROW)) begin
        hc_v = 3'(r);
        base = IDX_W'(r * ROW);
      end
    end
    dl_v = 4'(point - base);
    word = '0;
    word[{lane, 3'b000} +: 8] = comp_byte(hc_v, dl_v);
  end

endmodule

// File: rtl/calib_window_finder.sv
module calib_window_finder #(
  parameter int HC_ROWS    = 6,
  parameter int FINE_STEPS = 16,
  parameter int SUM_W      = 32,
  parameter int LVL_W      = 2,
  parameter int MIN_RUN    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [LVL_W-1:0]          level,
  input  logic [SUM_W-1:0]          golden,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [7:0]                req_setting,
  input  logic                      rsp_valid,
  output logic                      rsp_ready,
  input  logic [SUM_W-1:0]          rsp_sum,
  output logic [8*(2**LVL_W)-1:0]   comp_word,
  output logic                      done,
  output logic                      fail
);

  localparam int ROW    = FINE_STEPS + 1;
  localparam int GRID   = HC_ROWS * ROW;
  localparam int IDX_W  = $clog2(GRID + 1);
  localparam int WORD_W = 8 * (2 ** LVL_W);

  logic              launch;
  logic              sweep_busy;
  logic              sweep_done;
  logic [GRID-1:0]   results;
  logic              srch_active;
  logic              srch_report;
  logic [IDX_W-1:0]  best_len;
  logic [IDX_W-1:0]  mid;
  logic [LVL_W-1:0]  lvl_q;
  logic [WORD_W-1:0] enc_word;
  logic              too_short;

  assign launch    = start && !sweep_busy && !sweep_done && !srch_active;
  assign too_short = (best_len < IDX_W'(MIN_RUN));

  cal_sweep #(
    .HC_ROWS(HC_ROWS), .FINE_STEPS(FINE_STEPS), .SUM_W(SUM_W),
    .GRID(GRID), .IDX_W(IDX_W)
  ) u_sweep (
    .clk(clk), .rst_n(rst_n), .launch(launch), .golden(golden),
    .req_valid(req_valid), .req_ready(req_ready), .req_setting(req_setting),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_sum(rsp_sum),
    .busy(sweep_busy), .sweep_done(sweep_done), .results(results)
  );

  cal_run_search #(
    .ROW(ROW), .GRID(GRID), .IDX_W(IDX_W)
  ) u_search (
    .clk(clk), .rst_n(rst_n), .go(sweep_done), .results(results),
    .active(srch_active), .report(srch_report), .best_len(best_len), .mid(mid)
  );

  cal_encode #(
    .ROW(ROW), .HC_ROWS(HC_ROWS), .LVL_W(LVL_W), .IDX_W(IDX_W), .WORD_W(WORD_W)
  ) u_encode (
    .point(mid), .lane(lvl_q), .word(enc_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q     <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      comp_word <= '0;
    end else begin
      if (launch) lvl_q <= level;
      done <= srch_report;
      if (srch_report) begin
        fail      <= too_short;
        comp_word <= too_short ? '0 : enc_word;
      end
    end
  end

  // R8: the result strobe lasts one cycle
  a_r8_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: a short best run yields a failure with an empty word
  a_r6_short_rejected : assert property (@(posedge clk) disable iff (!rst_n)
    (srch_report && too_short) |=> (fail && comp_word == '0));

  // R8: outputs hold between result strobes
  a_r8_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !srch_report |=> ($stable(comp_word) && $stable(fail)));

endmodule

// File: tb/calib_window_finder_test.sv
`timescale 1ns/1ps
module calib_window_finder_test;

  typedef struct packed {
    logic [95:0] map;
    logic [1:0]  lvl;
    logic        xfail;
    logic [31:0] xword;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{96'h0,                                 2'd2, 1'b1, 32'h0000_0000},
    '{96'hFF << 36,                          2'd1, 1'b0, 32'h0000_7A00},
    '{96'hF,                                 2'd0, 1'b0, 32'h0000_0028},
    '{96'h7 << 69,                           2'd3, 1'b1, 32'h0000_0000},
    '{(96'h3F << 10) | (96'hF << 16),        2'd3, 1'b0, 32'hC800_0000},
    '{(96'h1F << 16) | (96'h1F << 56),       2'd2, 1'b0, 32'h0019_0000},
    '{96'hFFFF << 80,                        2'd0, 1'b0, 32'h0000_007D},
    '{{96{1'b1}},                            2'd1, 1'b0, 32'h0000_8800}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  level = 2'd0;
  logic [31:0] golden = 32'h0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [7:0]  req_setting;
  logic        rsp_valid = 1'b0;
  logic        rsp_ready;
  logic [31:0] rsp_sum = 32'h0;
  logic [31:0] comp_word;
  logic        done;
  logic        fail;

  int          checks = 0;
  int          errors = 0;
  logic [95:0] cur_map = '0;
  int          reqn = 0;
  int          seq_err = 0;
  int          ecyc = 0;

  always #10 clk = ~clk;

  calib_window_finder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .level(level), .golden(golden),
    .req_valid(req_valid), .req_ready(req_ready), .req_setting(req_setting),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_sum(rsp_sum),
    .comp_word(comp_word), .done(done), .fail(fail)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Checksum engine model with rotating back-pressure and response latency
  initial begin : engine
    bit pend = 0;
    int lat = 0;
    bit ok = 0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      ecyc++;
      req_ready = 1'b0;
      if (rsp_valid) begin
        rsp_valid = 1'b0;
        pend = 0;
      end else if (pend) begin
        if (lat == 0) begin
          rsp_valid = 1'b1;
          rsp_sum = ok ? golden : (golden ^ 32'h0000_0010);
        end else begin
          lat--;
        end
      end
      if (!pend && req_valid && (ecyc % 3 != 0)) begin
        req_ready = 1'b1;
        // R1 R2: order, encoding and handshake exclusivity of each request
        if (reqn >= 96 || req_setting != {4'(reqn % 16), 1'b1, 3'(reqn / 16)} || rsp_ready)
          seq_err++;
        ok = (reqn < 96) ? cur_map[reqn] : 1'b0;
        reqn++;
        pend = 1;
        lat = ecyc % 3;
      end
    end
  end

  task automatic wait_done(input bit extra_start);
    do begin
      @(negedge clk);
      start = extra_start && (reqn == 20 || reqn == 50);
    end while (!done);
    start = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input logic [31:0] gold, input bit extra_start, input string tag);
    cur_map = v.map;
    golden = gold;
    level = v.lvl;
    reqn = 0;
    seq_err = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    level = ~v.lvl;
    wait_done(extra_start);
    check(fail == v.xfail, {tag, " fail flag"}, 32'(fail), 32'(v.xfail));
    check(comp_word == v.xword, {tag, " word"}, comp_word, v.xword);
    check(seq_err == 0 && reqn == 96, "R1 R2 request sequence", 32'(reqn), 32'd96);
    @(negedge clk);
    check(!done && comp_word == v.xword, "R8 one-cycle done with held word", {31'b0, done}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!done && !fail && comp_word == 0 && !req_valid, "R10 reset outputs", comp_word, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !req_valid && !rsp_ready, "R10 idle after reset", {31'b0, req_valid}, 32'h0);

    // Table: R3 R4 R5 R6 R7 expected words worked out by hand
    for (int i = 0; i < NVEC; i++)
      run_vec(VECS[i], 32'hA500_0000 + 32'(i * 7), 1'b0, "R3 R4 R5 R6 R7 table");

    // R11: after an all-pass sweep, a three-long run alone must fail
    run_vec(VECS[7], 32'h1234_5678, 1'b0, "R11 all-pass before clear");
    run_vec(VECS[3], 32'h1234_5678, 1'b0, "R11 stale passes cleared");

    // R9: starts raised mid-sweep are ignored
    run_vec(VECS[1], 32'h0BAD_F00D, 1'b1, "R9 extra start ignored");

    // R9: start in the done cycle is accepted, old word held meanwhile
    cur_map = VECS[4].map;
    golden = 32'h0BAD_F00D;
    run_vec(VECS[5], 32'h0BAD_F00D, 1'b0, "R9 first run");
    cur_map = VECS[2].map;
    reqn = 0;
    seq_err = 0;
    level = VECS[2].lvl;
    start = 1'b0;
    // Re-run V5 to land on a done cycle, then start immediately
    cur_map = VECS[5].map;
    @(negedge clk);
    start = 1'b1;
    level = VECS[5].lvl;
    @(negedge clk);
    start = 1'b0;
    do @(negedge clk); while (!done);
    cur_map = VECS[2].map;
    reqn = 0;
    seq_err = 0;
    level = VECS[2].lvl;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(req_valid && !done && comp_word == VECS[5].xword, "R9 start in done cycle accepted",
          comp_word, VECS[5].xword);
    do @(negedge clk); while (!done);
    check(comp_word == VECS[2].xword && !fail, "R9 second result after back-to-back start",
          comp_word, VECS[2].xword);
    check(reqn == 96 && seq_err == 0, "R1 back-to-back sweep sequence", 32'(reqn), 32'd96);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

endmodule